// File: doc/BRIEF.md
# LUT Logic Fabric

A small programmable logic array for a microcontroller-class chip. Twenty-six lookup tables, each with five inputs, combine six primary input pins, the outputs of other tables and the state of four flip-flops. Eight output selectors then route table outputs or flip-flop states onto eight primary output pins. Software builds a custom combinational or sequential function by writing a truth table per LUT and one source code per LUT input and per output. After that the fabric runs without further software involvement.

The flip-flops run on a separate fabric clock, `fab_clk`. Each flip-flop captures the output of one of the first four LUTs, and none of them changes unless that clock rises. The configuration registers and the status register run on the bus clock, `clk`. A status register holds a copy of the eight output levels, taken on each bus clock edge. Configurations in which LUTs form a combinational loop are illegal and must not be written.

Top module: `lutfab_top`

## Requirements
- R1: A synchronous reset on `clk` clears every truth table, input code and output code to 0. A reset seen on a `fab_clk` rising edge clears all four flip-flops. After reset, `pin_o` and `status_o` read 0.
- R2: A write with `wr_en` high is decoded from `wr_addr[9:8]`. Region 0 writes `wr_data` as the truth table of LUT `wr_addr[4:0]`. Region 1 writes `wr_data[5:0]` as the code for input `wr_addr[2:0]` of LUT `wr_addr[7:3]`. Region 2 writes `wr_data[4:0]` as the code for output `wr_addr[2:0]`. Region 3, a LUT index above 25 and an input index above 4 are ignored.
- R3: The five selected input bits form an index, with input 0 as the least significant bit. The LUT output is the truth-table bit at that index.
- R4: Input codes 0 to 5 select pins 0 to 5, codes 6 to 31 select LUT outputs 0 to 25, and codes 32 to 35 select flip-flops 0 to 3.
- R5: An input whose code selects its own LUT's output reads logic 0.
- R6: Input codes 36 to 63 read logic 0.
- R7: Output codes 0 to 25 select LUT outputs 0 to 25 and codes 26 to 29 select flip-flops 0 to 3. Codes 30 and 31 drive 0.
- R8: On each rising edge of `fab_clk`, flip-flop k (k = 0 to 3) takes the output of LUT k. Without such an edge, the flip-flops hold their values whatever the pins do.
- R9: `status_o` equals the `pin_o` value sampled on the previous `clk` rising edge.
- R10: With `wr_en` low, address and data activity leaves the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock for configuration and status |
| rst | input | 1 | Synchronous active-high reset, sampled on both clocks |
| fab_clk | input | 1 | Fabric clock for the four state flip-flops |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 10 | Configuration address (region in bits 9:8) |
| wr_data | input | 32 | Configuration write data |
| pin_i | input | 6 | Primary inputs of the fabric |
| pin_o | output | 8 | Primary outputs of the fabric |
| status_o | output | 8 | Registered copy of the output levels |

## Verification
The hardest cases to reach are deep networks that mix flip-flop feedback with LUT chains: a LUT fed by a flip-flop, which in turn captured a LUT fed by another table. The bench generates random configurations with a hidden ordering that only lets a LUT read lower-numbered LUTs, so no loop can form. It also sprinkles in self-selecting codes and codes outside the valid range. A reference evaluator in the bench settles each configuration and predicts every output before and after each fabric clock pulse.

// File: rtl/lutfab_pkg.sv
package lutfab_pkg;
    localparam int N_LUT   = 26;
    localparam int LUT_K   = 5;
    localparam int N_PIN   = 6;
    localparam int N_FF    = 4;
    localparam int N_OUT   = 8;
    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 32;
    localparam int ISEL_W  = 6;
    localparam int OSEL_W  = 5;

    localparam int TT_W      = 1 << LUT_K;
    localparam int N_ISRC    = N_PIN + N_LUT + N_FF;
    localparam int N_OSRC    = N_LUT + N_FF;
    localparam int LUT_SLOT0 = N_PIN;
    localparam int LUT_IDX_W = $clog2(N_LUT);
    localparam int IN_IDX_W  = $clog2(LUT_K);
    localparam int OUT_IDX_W = $clog2(N_OUT);
    localparam int RGN_LSB   = ADDR_W - 2;

    typedef enum logic [1:0] {
        RGN_TRUTH  = 2'd0,
        RGN_INSEL  = 2'd1,
        RGN_OUTSEL = 2'd2,
        RGN_NONE   = 2'd3
    } region_e;

    typedef logic [ISEL_W-1:0] isel_t;
    typedef logic [OSEL_W-1:0] osel_t;
    typedef logic [TT_W-1:0]   truth_t;

    typedef struct packed {
        isel_t [LUT_K-1:0] sel;
        truth_t            truth;
    } lut_cfg_t;

    typedef struct packed {
        logic                 hit_tt;
        logic                 hit_isel;
        logic                 hit_osel;
        logic [LUT_IDX_W-1:0] lut;
        logic [IN_IDX_W-1:0]  inp;
        logic [OUT_IDX_W-1:0] out;
    } wr_dec_t;

    function automatic wr_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        wr_dec_t d;
        d = '0;
        case (region_e'(a[RGN_LSB +: 2]))
            RGN_TRUTH: begin
                d.lut    = a[LUT_IDX_W-1:0];
                d.hit_tt = (int'(a[LUT_IDX_W-1:0]) < N_LUT);
            end
            RGN_INSEL: begin
                d.lut      = a[IN_IDX_W +: LUT_IDX_W];
                d.inp      = a[IN_IDX_W-1:0];
                d.hit_isel = (int'(a[IN_IDX_W +: LUT_IDX_W]) < N_LUT) &&
                             (int'(a[IN_IDX_W-1:0]) < LUT_K);
            end
            RGN_OUTSEL: begin
                d.out      = a[OUT_IDX_W-1:0];
                d.hit_osel = 1'b1;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

    function automatic logic pick_isrc(input logic [N_ISRC-1:0] pool, input isel_t c);
        return (int'(c) < N_ISRC) ? pool[c] : 1'b0;
    endfunction

    function automatic logic pick_osrc(input logic [N_OSRC-1:0] pool, input osel_t c);
        return (int'(c) < N_OSRC) ? pool[c] : 1'b0;
    endfunction
endpackage

// File: rtl/lutfab_cfg.sv
module lutfab_cfg
    import lutfab_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    output lut_cfg_t [N_LUT-1:0]         lut_cfg_o,
    output osel_t    [N_OUT-1:0]         osel_o
);
    wr_dec_t dec;

    always_comb dec = decode_addr(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            lut_cfg_o <= '0;
            osel_o    <= '0;
        end else if (wr_en) begin
            if (dec.hit_tt)
                lut_cfg_o[dec.lut].truth <= wr_data[TT_W-1:0];
            if (dec.hit_isel)
                lut_cfg_o[dec.lut].sel[dec.inp] <= wr_data[ISEL_W-1:0];
            if (dec.hit_osel)
                osel_o[dec.out] <= wr_data[OSEL_W-1:0];
        end
    end
endmodule

// File: rtl/lutfab_cell.sv
module lutfab_cell
    import lutfab_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic [N_ISRC-1:0] pool_i,
    input  lut_cfg_t          cfg_i,
    output logic              y_o
);
    logic [N_ISRC-1:0] pool_m;
    logic [LUT_K-1:0]  idx;

    always_comb begin
        pool_m = pool_i;
        pool_m[LUT_SLOT0 + IDX] = 1'b0;
        for (int k = 0; k < LUT_K; k++)
            idx[k] = pick_isrc(pool_m, cfg_i.sel[k]);
    end

    assign y_o = cfg_i.truth[idx];
endmodule

// File: rtl/lutfab_ffbank.sv
module lutfab_ffbank
    import lutfab_pkg::*;
(
    input  logic            fab_clk,
    input  logic            rst,
    input  logic [N_FF-1:0] d_i,
    output logic [N_FF-1:0] q_o
);
    always_ff @(posedge fab_clk) begin
        if (rst) q_o <= '0;
        else     q_o <= d_i;
    end
endmodule

// File: rtl/lutfab_outmux.sv
module lutfab_outmux
    import lutfab_pkg::*;
(
    input  logic [N_LUT-1:0]     lut_i,
    input  logic [N_FF-1:0]      ff_i,
    input  osel_t [N_OUT-1:0]    osel_i,
    output logic [N_OUT-1:0]     y_o
);
    logic [N_OSRC-1:0] pool;

    assign pool = {ff_i, lut_i};

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        assign y_o[j] = pick_osrc(pool, osel_i[j]);
    end
endmodule

// File: rtl/lutfab_top.sv
module lutfab_top
    import lutfab_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fab_clk,
    input  logic              wr_en,
    input  logic [9:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [5:0]        pin_i,
    output logic [7:0]        pin_o,
    output logic [7:0]        status_o
);
    lut_cfg_t [N_LUT-1:0] cfg_q;
    osel_t    [N_OUT-1:0] osel_q;
    logic     [N_LUT-1:0] lut_y;
    logic     [N_FF-1:0]  ff_q;
    logic     [N_ISRC-1:0] pool;

    lutfab_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .lut_cfg_o (cfg_q),
        .osel_o    (osel_q)
    );

    assign pool = {ff_q, lut_y, pin_i};

    for (genvar i = 0; i < N_LUT; i++) begin : g_lut
        lutfab_cell #(.IDX(i)) u_cell (
            .pool_i (pool),
            .cfg_i  (cfg_q[i]),
            .y_o    (lut_y[i])
        );
    end

    lutfab_ffbank u_ff (
        .fab_clk (fab_clk),
        .rst     (rst),
        .d_i     (lut_y[N_FF-1:0]),
        .q_o     (ff_q)
    );

    lutfab_outmux u_out (
        .lut_i  (lut_y),
        .ff_i   (ff_q),
        .osel_i (osel_q),
        .y_o    (pin_o)
    );

    always_ff @(posedge clk) begin
        if (rst) status_o <= '0;
        else     status_o <= pin_o;
    end
endmodule

// File: rtl/lutfab_chk.sv
module lutfab_chk
    import lutfab_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          fab_clk,
    input logic                          wr_en,
    input logic [N_LUT-1:0]              lut_y,
    input logic [N_FF-1:0]               ff_q,
    input logic [N_OUT*OSEL_W-1:0]       osel_flat,
    input logic [N_LUT*$bits(lut_cfg_t)-1:0] cfg_flat,
    input logic [N_OUT-1:0]              pin_o,
    input logic [N_OUT-1:0]              status_o
);
    // R1: with configuration cleared every table reads 0
    a_r1_luts_idle_after_rst: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lut_y == '0));

    // R1: flip-flops cleared by a reset seen on the fabric clock
    a_r1_ff_cleared: assert property (@(posedge fab_clk) disable iff (rst)
        $past(rst) |-> (ff_q == '0));

    // R8: each fabric edge captures the low LUT outputs
    a_r8_ff_capture: assert property (@(posedge fab_clk) disable iff (rst)
        !$past(rst) |-> (ff_q == $past(lut_y[N_FF-1:0])));

    // R9: status lags the output pins by one bus clock
    a_r9_status_lag: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (status_o == $past(pin_o)));

    // R10: no strobe, no configuration change
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !rst) |=> ($stable(cfg_flat) && $stable(osel_flat)));

    // R7: output codes past the last flip-flop drive 0
    for (genvar j = 0; j < N_OUT; j++) begin : g_o
        a_r7_osel_high_zero: assert property (@(posedge clk) disable iff (rst)
            (int'(osel_flat[j*OSEL_W +: OSEL_W]) >= N_OSRC) |-> !pin_o[j]);
    end
endmodule

bind lutfab_top lutfab_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .fab_clk   (fab_clk),
    .wr_en     (wr_en),
    .lut_y     (lut_y),
    .ff_q      (ff_q),
    .osel_flat (osel_q),
    .cfg_flat  (cfg_q),
    .pin_o     (pin_o),
    .status_o  (status_o)
);

// File: tb/test_lutfab_top.sv
module test_lutfab_top;
    import lutfab_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fab_clk = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  pin_i = '0;
    logic [7:0]  pin_o;
    logic [7:0]  status_o;

    lutfab_top i_lutfab_top (
        .clk      (clk),
        .rst      (rst),
        .fab_clk  (fab_clk),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pin_i    (pin_i),
        .pin_o    (pin_o),
        .status_o (status_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    logic [31:0] m_tt   [N_LUT];
    logic [5:0]  m_sel  [N_LUT][LUT_K];
    logic [4:0]  m_osel [N_OUT];
    logic [3:0]  m_ff;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        bit         kind;   // 0: pins, 1: status
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];

    function automatic logic [N_LUT-1:0] m_luts();
        logic [N_LUT-1:0] lv = '0;
        for (int pass = 0; pass < N_LUT; pass++) begin
            for (int i = 0; i < N_LUT; i++) begin
                logic [4:0] idx;
                for (int k = 0; k < LUT_K; k++) begin
                    int c = int'(m_sel[i][k]);
                    if (c < 6)       idx[k] = pin_i[c];
                    else if (c < 32) idx[k] = (c - 6 == i) ? 1'b0 : lv[c-6];
                    else if (c < 36) idx[k] = m_ff[c-32];
                    else             idx[k] = 1'b0;
                end
                lv[i] = m_tt[i][idx];
            end
        end
        return lv;
    endfunction

    function automatic logic [7:0] m_outs();
        logic [N_LUT-1:0] lv = m_luts();
        logic [7:0] o;
        for (int j = 0; j < N_OUT; j++) begin
            int c = int'(m_osel[j]);
            if (c < 26)      o[j] = lv[c];
            else if (c < 30) o[j] = m_ff[c-26];
            else             o[j] = 1'b0;
        end
        return o;
    endfunction

    function automatic void m_clear();
        for (int i = 0; i < N_LUT; i++) begin
            m_tt[i] = '0;
            for (int k = 0; k < LUT_K; k++) m_sel[i][k] = '0;
        end
        for (int j = 0; j < N_OUT; j++) m_osel[j] = '0;
    endfunction

    function automatic logic [9:0] a_tt(input int i);
        return {2'd0, 3'd0, 5'(i)};
    endfunction
    function automatic logic [9:0] a_sel(input int i, input int k);
        return {2'd1, 5'(i), 3'(k)};
    endfunction
    function automatic logic [9:0] a_osel(input int j);
        return {2'd2, 5'd0, 3'(j)};
    endfunction

    // monitor: compares queued expectations just after each bus edge
    always begin
        @(posedge clk);
        #1;
        while (sbq.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it  = sbq.pop_front();
            got = it.kind ? status_o : pin_o;
            n_chk++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s (%s): got %b expected %b", it.tag,
                         it.kind ? "status" : "pins", got, it.exp);
            end
        end
    end

    task automatic expect_now(input string tag);
        item_t a;
        item_t b;
        a.kind = 1'b0; a.exp = m_outs(); a.tag = tag;
        b.kind = 1'b1; b.exp = a.exp;    b.tag = {tag, " R9"};
        sbq.push_back(a);
        sbq.push_back(b);
        @(posedge clk);
        #2;
    endtask

    task automatic wr_cfg(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a[9:8])
            2'd0: if (a[4:0] < 5'd26) m_tt[a[4:0]] = d;
            2'd1: if (a[7:3] < 5'd26 && a[2:0] < 3'd5) m_sel[a[7:3]][a[2:0]] = d[5:0];
            2'd2: m_osel[a[2:0]] = d[4:0];
            default: ;
        endcase
    endtask

    task automatic set_pins(input logic [5:0] v);
        @(negedge clk);
        pin_i = v;
    endtask

    task automatic fab_pulse();
        logic [N_LUT-1:0] lv;
        @(negedge clk);
        lv = m_luts();
        m_ff = rst ? 4'd0 : lv[3:0];
        #1 fab_clk = 1'b1;
        #1 fab_clk = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        m_clear();
        fab_pulse();
        fab_pulse();
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [5:0] rand_sel(input int i);
        int r = int'($urandom % 5);
        case (r)
            0: return 6'($urandom % 6);
            1: return (i > 0) ? 6'(6 + ($urandom % i)) : 6'($urandom % 6);
            2: return 6'(32 + ($urandom % 4));
            3: return 6'(36 + ($urandom % 28));
            default: return 6'(6 + i);
        endcase
    endfunction

    initial begin
        m_clear();
        m_ff = '0;
        do_reset();

        // R1: cleared state
        expect_now("R1 reset state");

        // R2 R3: LUT0 reads pins 0..4, one set bit at index 19
        for (int k = 0; k < LUT_K; k++) wr_cfg(a_sel(0, k), 32'(k));
        wr_cfg(a_tt(0), 32'h0008_0000);
        wr_cfg(a_osel(0), 32'd0);
        set_pins(6'b010011); expect_now("R3 index 19 hit");
        set_pins(6'b000011); expect_now("R3 index 3 miss");
        set_pins(6'b110011); expect_now("R3 pin5 unused");

        // R4: LUT1 = LUT0 AND pin5
        wr_cfg(a_sel(1, 0), 32'd6);
        wr_cfg(a_sel(1, 1), 32'd5);
        wr_cfg(a_sel(1, 2), 32'd63);
        wr_cfg(a_sel(1, 3), 32'd63);
        wr_cfg(a_sel(1, 4), 32'd63);
        wr_cfg(a_tt(1), 32'h0000_0008);
        wr_cfg(a_osel(1), 32'd1);
        set_pins(6'b110011); expect_now("R4 lut and pin");
        set_pins(6'b010011); expect_now("R4 pin5 low");

        // R5: LUT2 input 0 picks its own slot, table needs it high
        wr_cfg(a_sel(2, 0), 32'd8);
        for (int k = 1; k < LUT_K; k++) wr_cfg(a_sel(2, k), 32'd40);
        wr_cfg(a_tt(2), 32'h0000_0002);
        wr_cfg(a_osel(2), 32'd2);
        expect_now("R5 own slot low");

        // R6: LUT3 all inputs out of range -> index 0
        for (int k = 0; k < LUT_K; k++) wr_cfg(a_sel(3, k), 32'(36 + 5 * k));
        wr_cfg(a_tt(3), 32'h0000_0001);
        wr_cfg(a_osel(3), 32'd3);
        set_pins(6'b111111); expect_now("R6 high code reads 0");

        // R7: output codes 30/31 drive 0; 26 picks flip-flop 0
        wr_cfg(a_osel(4), 32'd31);
        wr_cfg(a_osel(5), 32'd30);
        wr_cfg(a_osel(6), 32'd26);
        wr_cfg(a_osel(7), 32'd29);
        expect_now("R7 output code range");

        // R8: capture, then hold while pins move
        set_pins(6'b110011);
        fab_pulse(); expect_now("R8 capture");
        set_pins(6'b000000); expect_now("R8 hold without edge");
        wr_cfg(a_sel(4, 0), 32'd32);
        wr_cfg(a_tt(4), 32'h0000_0002);
        wr_cfg(a_osel(4), 32'd4);
        expect_now("R4 R8 flip-flop feeds lut");
        fab_pulse(); expect_now("R8 second capture");

        // R2: ignored addresses
        wr_cfg({2'd3, 8'h00}, 32'hFFFF_FFFF);
        wr_cfg(a_tt(27), 32'hFFFF_FFFF);
        wr_cfg({2'd1, 5'd1, 3'd6}, 32'd0);
        set_pins(6'b110011); expect_now("R2 unmapped writes ignored");

        // R10: activity without strobe
        @(negedge clk);
        wr_addr = a_tt(0); wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_addr = a_osel(0); wr_data = 32'd27;
        set_pins(6'b000011); expect_now("R10 no strobe");

        // random acyclic networks
        for (int round = 0; round < 8; round++) begin
            for (int i = 0; i < N_LUT; i++) begin
                wr_cfg(a_tt(i), $urandom);
                for (int k = 0; k < LUT_K; k++) wr_cfg(a_sel(i, k), 32'(rand_sel(i)));
            end
            for (int j = 0; j < N_OUT; j++) wr_cfg(a_osel(j), 32'($urandom % 32));
            for (int p = 0; p < 6; p++) begin
                set_pins(6'($urandom));
                if ($urandom % 2) fab_pulse();
                expect_now("R3 R4 R5 R6 R7 R8 random network");
            end
        end

        // R1: reset in the middle of operation
        do_reset();
        set_pins(6'b101010); expect_now("R1 reset after use");

        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all): got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule